// File: doc/BRIEF.md
# System Control Register Access Unit

This unit sits beside a processor core and serves the coprocessor transfer instructions aimed at the system control coprocessor. Each cycle it may receive one instruction word together with a valid strobe, the current processor mode and the value of the core register involved. It then classifies the word. Register-transfer reads and writes issued from a privileged mode complete normally. The same transfers issued from user mode raise an undefined-instruction trap. Coprocessor data operations and memory transfers aimed at this coprocessor always trap, whatever the mode.

Register 0 is read-only. Its opcode_2 field selects which value it returns: the value 1 gives the cache type word, and any other value gives the identification word. Registers 1, 2 and 3 are writable control registers that start at zero. Every claimed instruction is answered one cycle later by exactly one single-cycle pulse, either done or trap. Read data travels with done. Instructions for other coprocessors, and words that are not coprocessor instructions, are not claimed and get no answer.

Top module: `sysctl_cop_unit`

## Requirements
- R1: After reset, done and trap are low, rd_data is zero and control registers 1 to 3 read back as zero.
- R2: A register transfer (bits 27:24 = 4'b1110, bit 4 = 1, bits 11:8 = 15) issued while mode equals 5'b10000 (user) traps and changes no register. Every other mode value is privileged.
- R3: A coprocessor data operation (bits 27:24 = 4'b1110, bit 4 = 0) or a memory transfer (bits 27:25 = 3'b110) with bits 11:8 = 15 traps in every mode and changes no register.
- R4: A word whose bits 11:8 are not 15, or that matches none of the encodings above, produces neither done nor trap and changes no register.
- R5: A privileged read (bit 20 = 1) of register 0 (bits 19:16) with opcode_2 (bits 7:5) equal to 1 returns the CACHE_TYPE parameter.
- R6: A privileged read of register 0 with any other opcode_2 returns {IMPL[7:0], SPEC[3:0], ARCH[3:0], PART[11:0], LAYOUT_REV[3:0]}, most significant field first.
- R7: A privileged write (bit 20 = 0) to register 1, 2 or 3 stores wr_data in that register. A read in the next cycle returns the new value.
- R8: A privileged write to register 0 completes with done and changes nothing.
- R9: A privileged transfer with nonzero opcode_1 (bits 23:21) or nonzero CRm (bits 3:0) completes with done, writes nothing and reads zero.
- R10: A claimed instruction gives exactly one of done or trap, high for one cycle, on the cycle after the strobe.
- R11: rd_data is zero on every cycle except a done that answers a read.
- R12: Privileged transfers to registers 4 to 15 complete with done. They read zero and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_valid | input | 1 | Instruction word present this cycle |
| insn_word | input | 32 | Instruction word |
| cpu_mode | input | 5 | Processor mode; 5'b10000 is user |
| wr_data | input | 32 | Core register value for writes |
| rd_data | output | 32 | Read result, valid with done |
| done | output | 1 | Instruction completed |
| trap | output | 1 | Undefined-instruction trap |

## Verification
The bench overrides LAYOUT_REV with 4'h6 and CACHE_TYPE with 32'h1D15_2A93. These values differ from the defaults, and no field of the identification word equals its neighbour. A swapped field or a wrong opcode_2 selection therefore shows up in the read data. The coprocessor number stays at 15, so the bench reaches the unclaimed path by changing bits 11:8. The width and count parameters stay at their defaults, which puts every control-register index and the gap above them (registers 4 to 15) within reach of the random stream.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_XFER  = 2'd1,
        CLS_ALWAYS_TRAP = 2'd2
    } insn_cls_e;

    typedef struct packed {
        insn_cls_e  cls;
        logic       is_read;
        logic [2:0] opc1;
        logic [3:0] reg_n;
        logic [2:0] opc2;
        logic [3:0] sub_m;
    } insn_dec_t;

    localparam logic [4:0] MODE_USER = 5'b10000;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int unsigned COP_NUM = 15
) (
    input  logic [31:0] word_i,
    output insn_dec_t   dec_o
);
    localparam logic [3:0] COP_ID = 4'(COP_NUM);

    logic is_mine;
    logic is_xfer;
    logic is_dataop;
    logic is_mem;

    always_comb begin
        is_mine   = (word_i[11:8] == COP_ID);
        is_xfer   = (word_i[27:24] == 4'b1110) && word_i[4];
        is_dataop = (word_i[27:24] == 4'b1110) && !word_i[4];
        is_mem    = (word_i[27:25] == 3'b110);

        dec_o.cls = CLS_NONE;
        if (is_mine) begin
            if (is_xfer)
                dec_o.cls = CLS_XFER;
            else if (is_dataop || is_mem)
                dec_o.cls = CLS_ALWAYS_TRAP;
        end
        dec_o.is_read = word_i[20];
        dec_o.opc1    = word_i[23:21];
        dec_o.reg_n   = word_i[19:16];
        dec_o.opc2    = word_i[7:5];
        dec_o.sub_m   = word_i[3:0];
    end
endmodule

// File: rtl/sysctl_idrom.sv
module sysctl_idrom #(
    parameter logic [7:0]  IMPL       = 8'h5A,
    parameter logic [3:0]  SPEC       = 4'h1,
    parameter logic [3:0]  ARCH       = 4'h2,
    parameter logic [11:0] PART       = 12'h3C7,
    parameter logic [3:0]  LAYOUT_REV = 4'h3,
    parameter logic [31:0] CACHE_TYPE = 32'h0D17_2192
) (
    input  logic [2:0]  opc2_i,
    output logic [31:0] value_o
);
    localparam logic [31:0] ID_WORD = {IMPL, SPEC, ARCH, PART, LAYOUT_REV};

    always_comb begin
        if (opc2_i == 3'd1)
            value_o = CACHE_TYPE;
        else
            value_o = ID_WORD;
    end
endmodule

// File: rtl/sysctl_ctrl_regs.sv
module sysctl_ctrl_regs #(
    parameter int unsigned DW       = 32,
    parameter int unsigned NUM_REGS = 3,
    parameter int unsigned BASE_IDX = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [3:0]    wsel_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [3:0]    rsel_i,
    output logic          rhit_o,
    output logic [DW-1:0] rdata_o
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DW-1:0] regs;
    } state_t;

    state_t st_d, st_q;
    logic [NUM_REGS-1:0] wr_hit;
    logic [NUM_REGS-1:0] rd_hit;

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_sel
        assign wr_hit[gi] = we_i && (wsel_i == 4'(BASE_IDX + gi));
        assign rd_hit[gi] = (rsel_i == 4'(BASE_IDX + gi));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_hit[i])
                st_d.regs[i] = wdata_i;
        end
    end

    always_comb begin
        rhit_o  = |rd_hit;
        rdata_o = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_hit[i])
                rdata_o = st_q.regs[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_chk
        p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (we_i && wsel_i == 4'(BASE_IDX + gi)) |=> (st_q.regs[gi] == $past(wdata_i)));
    end

    p_hold_without_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(st_q.regs));
endmodule

// File: rtl/sysctl_cop_unit.sv
module sysctl_cop_unit
    import sysctl_pkg::*;
#(
    parameter int unsigned COP_NUM    = 15,
    parameter int unsigned NUM_CTRL   = 3,
    parameter logic [7:0]  IMPL       = 8'h5A,
    parameter logic [3:0]  SPEC       = 4'h1,
    parameter logic [3:0]  ARCH       = 4'h2,
    parameter logic [11:0] PART       = 12'h3C7,
    parameter logic [3:0]  LAYOUT_REV = 4'h3,
    parameter logic [31:0] CACHE_TYPE = 32'h0D17_2192
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        insn_valid,
    input  logic [31:0] insn_word,
    input  logic [4:0]  cpu_mode,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        done,
    output logic        trap
);
    localparam int unsigned DW = 32;

    typedef struct packed {
        logic          done;
        logic          trap;
        logic [DW-1:0] rdata;
    } resp_t;

    insn_dec_t     dec;
    logic [DW-1:0] rom_val;
    logic [DW-1:0] reg_val;
    logic          reg_hit;
    logic          priv;
    logic          served;
    logic          ignored;
    logic          reg_we;
    resp_t         rsp_d, rsp_q;

    sysctl_decode #(.COP_NUM(COP_NUM)) u_dec (
        .word_i (insn_word),
        .dec_o  (dec)
    );

    sysctl_idrom #(
        .IMPL(IMPL), .SPEC(SPEC), .ARCH(ARCH), .PART(PART),
        .LAYOUT_REV(LAYOUT_REV), .CACHE_TYPE(CACHE_TYPE)
    ) u_rom (
        .opc2_i  (dec.opc2),
        .value_o (rom_val)
    );

    sysctl_ctrl_regs #(.DW(DW), .NUM_REGS(NUM_CTRL), .BASE_IDX(1)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we),
        .wsel_i  (dec.reg_n),
        .wdata_i (wr_data),
        .rsel_i  (dec.reg_n),
        .rhit_o  (reg_hit),
        .rdata_o (reg_val)
    );

    always_comb begin
        priv    = (cpu_mode != MODE_USER);
        served  = insn_valid && (dec.cls == CLS_XFER) && priv;
        ignored = (dec.opc1 != 3'd0) || (dec.sub_m != 4'd0);
        reg_we  = served && !dec.is_read && !ignored;

        rsp_d.done  = served;
        rsp_d.trap  = insn_valid &&
                      ((dec.cls == CLS_ALWAYS_TRAP) ||
                       ((dec.cls == CLS_XFER) && !priv));
        rsp_d.rdata = '0;
        if (served && dec.is_read && !ignored) begin
            if (dec.reg_n == 4'd0)
                rsp_d.rdata = rom_val;
            else if (reg_hit)
                rsp_d.rdata = reg_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rsp_q <= '0;
        else
            rsp_q <= rsp_d;
    end

    assign done    = rsp_q.done;
    assign trap    = rsp_q.trap;
    assign rd_data = rsp_q.rdata;

    p_one_answer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && trap));
    p_answer_needs_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || trap) |-> $past(insn_valid));
    p_user_traps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && dec.cls == CLS_XFER && cpu_mode == MODE_USER) |=> trap);
    p_always_trap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && dec.cls == CLS_ALWAYS_TRAP) |=> (trap && !done));
    p_unclaimed_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.cls == CLS_NONE) |=> !(done || trap));
    p_rdata_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (rd_data == '0));
    p_no_write_on_trap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_d.trap |-> !reg_we);
endmodule

// File: tb/sim_sysctl_cop_unit.sv
module sim_sysctl_cop_unit;
    localparam logic [7:0]  T_IMPL  = 8'h5A;
    localparam logic [3:0]  T_SPEC  = 4'h1;
    localparam logic [3:0]  T_ARCH  = 4'h2;
    localparam logic [11:0] T_PART  = 12'h3C7;
    localparam logic [3:0]  T_REV   = 4'h6;
    localparam logic [31:0] T_CTYPE = 32'h1D15_2A93;
    localparam logic [31:0] T_ID    = {T_IMPL, T_SPEC, T_ARCH, T_PART, T_REV};
    localparam logic [4:0]  USR     = 5'b10000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn_word = '0;
    logic [4:0]  cpu_mode = 5'h13;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        done;
    logic        trap;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [31:0] shadow [1:3];

    always #2 clk = ~clk;

    sysctl_cop_unit #(.LAYOUT_REV(T_REV), .CACHE_TYPE(T_CTYPE)) u0 (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
        .cpu_mode(cpu_mode), .wr_data(wr_data), .rd_data(rd_data),
        .done(done), .trap(trap)
    );

    function automatic logic [31:0] mk_xfer(bit rd, logic [2:0] op1, logic [3:0] crn,
                                            logic [3:0] cp, logic [2:0] op2, logic [3:0] crm);
        return {4'hE, 4'b1110, op1, rd, crn, 4'h3, cp, op2, 1'b1, crm};
    endfunction

    // expected {done, trap, rdata}; updates shadow when the write lands
    function automatic logic [33:0] model(logic [31:0] w, logic [4:0] m, logic [31:0] wd);
        bit mine, xfer, other;
        logic [31:0] rv;
        mine  = (w[11:8] == 4'd15);
        xfer  = (w[27:24] == 4'b1110) && w[4];
        other = ((w[27:24] == 4'b1110) && !w[4]) || (w[27:25] == 3'b110);
        if (!mine || !(xfer || other)) return {2'b00, 32'h0};
        if (other || m == USR) return {2'b01, 32'h0};
        if (w[23:21] != 0 || w[3:0] != 0) return {2'b10, 32'h0};
        rv = '0;
        if (w[20]) begin
            if (w[19:16] == 0) rv = (w[7:5] == 3'd1) ? T_CTYPE : T_ID;
            else if (w[19:16] <= 3) rv = shadow[w[19:16]];
        end else if (w[19:16] >= 1 && w[19:16] <= 3) begin
            shadow[w[19:16]] = wd;
        end
        return {2'b10, rv};
    endfunction

    task automatic check(string req, logic [33:0] act, logic [33:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got done=%0b trap=%0b rd=%h, want done=%0b trap=%0b rd=%h",
                     req, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
        end
    endtask

    task automatic issue(string req, logic [31:0] w, logic [4:0] m, logic [31:0] wd);
        logic [33:0] exp;
        insn_word  = w;
        cpu_mode   = m;
        wr_data    = wd;
        insn_valid = 1'b1;
        exp = model(w, m, wd);
        @(negedge clk);
        insn_valid = 1'b0;
        check(req, {done, trap, rd_data}, exp);
    endtask

    task automatic idle_check(string req);
        @(negedge clk);
        check(req, {done, trap, rd_data}, 34'h0);
    endtask

    initial begin
        for (int i = 1; i <= 3; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {done, trap, rd_data}, 34'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 1; i <= 3; i++)
            issue("R1 reset regs", mk_xfer(1, 0, 4'(i), 15, 0, 0), 5'h13, '0);
        issue("R6 id op2=0", mk_xfer(1, 0, 0, 15, 0, 0), 5'h1F, '0);
        issue("R6 id op2=7", mk_xfer(1, 0, 0, 15, 7, 0), 5'h13, '0);
        issue("R5 cache type", mk_xfer(1, 0, 0, 15, 1, 0), 5'h12, '0);
        issue("R7 write r2", mk_xfer(0, 0, 2, 15, 0, 0), 5'h13, 32'hA5A5_1234);
        issue("R7 readback r2", mk_xfer(1, 0, 2, 15, 0, 0), 5'h13, '0);
        issue("R2 user write", mk_xfer(0, 0, 2, 15, 0, 0), USR, 32'hDEAD_BEEF);
        issue("R2 user read", mk_xfer(1, 0, 0, 15, 0, 0), USR, '0);
        issue("R2 unchanged", mk_xfer(1, 0, 2, 15, 0, 0), 5'h13, '0);
        issue("R3 data op", {8'hEE, 16'h1234, 4'hF, 4'h0} & 32'hFFFF_FFEF | 32'h0000_0F00, 5'h13, '0);
        issue("R3 memory xfer", 32'hED81_5F04, USR, '0);
        issue("R4 other cop", mk_xfer(1, 0, 0, 14, 0, 0), 5'h13, '0);
        issue("R4 not cop", 32'hE1A0_0F01, 5'h13, '0);
        issue("R8 write r0", mk_xfer(0, 0, 0, 15, 0, 0), 5'h13, 32'h1111_2222);
        issue("R8 r0 intact", mk_xfer(1, 0, 0, 15, 0, 0), 5'h13, '0);
        issue("R9 opc1 write", mk_xfer(0, 3, 1, 15, 0, 0), 5'h13, 32'h7777_0000);
        issue("R9 crm write", mk_xfer(0, 0, 1, 15, 0, 5), 5'h13, 32'h7777_0001);
        issue("R9 opc1 read", mk_xfer(1, 2, 2, 15, 0, 0), 5'h13, '0);
        issue("R9 r1 intact", mk_xfer(1, 0, 1, 15, 0, 0), 5'h13, '0);
        issue("R12 write r9", mk_xfer(0, 0, 9, 15, 0, 0), 5'h13, 32'h5555_5555);
        issue("R12 read r15", mk_xfer(1, 0, 15, 15, 0, 0), 5'h13, '0);
        idle_check("R10 single pulse");
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] w;
            logic [4:0]  m;
            int unsigned k;
            k = $urandom_range(0, 9);
            w = $urandom;
            if (k < 6)
                w = mk_xfer(w[20], ($urandom_range(0, 7) == 0) ? w[23:21] : 3'd0,
                            4'($urandom_range(0, 5)), 15, w[7:5],
                            ($urandom_range(0, 7) == 0) ? w[3:0] : 4'd0);
            else if (k == 6) w[11:8] = 4'hF;
            m = ($urandom_range(0, 3) == 0) ? USR : 5'($urandom_range(17, 31));
            issue("R11 random", w, m, $urandom);
            if ($urandom_range(0, 9) == 0) idle_check("R10 random gap");
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got no end, want end");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule